// File: doc/BRIEF.md
# Fixed-Length Burst Early-End Monitor

This block watches the transfer-control signals on the slave side of an AHB-Lite bus. It follows every fixed-length burst (4, 8 or 16 beats, incrementing or wrapping) one beat at a time. It detects a burst that stops before its full beat count. No error response is needed for this: the block sees the cut from the HTRANS sequence alone, when an IDLE or a new NONSEQ arrives while beats are still owed.

When a cut is detected, the block drops its remaining-beat tracking, so the next transfer starts from a clean state. A NONSEQ that causes a cut is taken as the first beat of the next burst and is not lost. The block also checks that each SEQ beat carries the address the previous beat implies, with wrapping applied for wrapping bursts.

For diagnosis it presents several registered status outputs: the tracker state, a sticky early-end flag, a sticky address-violation flag, a saturating early-end counter, and two shift histories. One history holds the recent HTRANS codes and the other marks which of those transfers ended a burst early. A single clear strobe clears the counter and both sticky flags.

Top module: `burst_watch`

## Requirements
- R1: After a synchronous reset, the outputs read as follows: state IDLE (code 0), counter zero, both sticky flags low, both histories zero, and the event pulse low.
- R2: A fixed burst of the right length produces no early-end event and does not change the counter. The burst is a NONSEQ with HBURST code 2 to 7 (WRAP4=010, INCR4=011, WRAP8=100, INCR8=101, WRAP16=110, INCR16=111), followed by 3, 7 or 15 SEQ beats, then IDLE or NONSEQ.
- R3: A burst can be cut by an accepted IDLE (HTRANS=00) while SEQ beats are still owed. In the cycle after that edge, `term_pulse` is high, the counter has gone up by one, `early_flag` is set and the state reads TERM (code 3). One cycle after that, the state reads IDLE (code 0).
- R4: A burst can also be cut by an accepted NONSEQ (HTRANS=10). That edge is counted as an early end, and the state reads START (code 1) because the NONSEQ opens a new burst. That new burst then runs to its own full length with no further event.
- R5: An edge is sampled only when `hsel` and `hready` are both high. A BUSY beat (HTRANS=01) does not count as a beat and does not end a burst, but it is still logged.
- R6: SINGLE (000) and undefined-length INCR (001) transfers are never reported as ending early.
- R7: The early-end counter is CNT_W bits wide and holds at 2^CNT_W-1 once it reaches that value.
- R8: `clr` clears the counter and both sticky flags. If an early end happens on the same edge as a clear, the counter reads 1 and `early_flag` reads 1.
- R9: Each accepted edge shifts its HTRANS code into `trans_log[1:0]` and moves older codes up by two bits. It also shifts a 1 into `term_log[0]` if that transfer ended a burst early, and a 0 otherwise.
- R10: An accepted SEQ sets `addr_err` in two cases: when its address differs from the previous beat's address plus 2^HSIZE (wrapped within a len*2^HSIZE aligned window for WRAP bursts), and when no beat precedes it. Correct addresses leave `addr_err` low.
- R11: The state reads CONT (code 2) after an accepted SEQ, and START (code 1) after an accepted NONSEQ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| hsel | input | 1 | Slave select |
| hready | input | 1 | Transfer-complete indication from the bus |
| htrans | input | 2 | Transfer type |
| hburst | input | 3 | Burst type |
| hsize | input | 3 | Transfer size, log2 of bytes |
| haddr | input | AW | Transfer address |
| clr | input | 1 | Clears counter and sticky flags |
| state | output | 2 | Tracker state: 0 IDLE, 1 START, 2 CONT, 3 TERM |
| term_pulse | output | 1 | One-cycle marker of an early end |
| early_flag | output | 1 | Sticky early-end flag |
| addr_err | output | 1 | Sticky SEQ address violation flag |
| term_cnt | output | CNT_W | Saturating early-end count |
| trans_log | output | 2*LOG_D | Recent HTRANS codes, newest in the low bits |
| term_log | output | LOG_D | Early-end marks aligned with trans_log |

## Verification
The assertions check the following on every cycle:
- the histories and the counter do not move on cycles where no transfer is accepted;
- each event pulse follows an accepted IDLE or NONSEQ;
- the pulse always comes with the sticky flag;
- the counter never goes down without a clear;
- the TERM state never lasts for two cycles;
- the newest history entry equals the code that was accepted.

Some behaviour can only be shown by the bench scenarios. These cover the exact beat count at which each burst type stops being early, the wrap arithmetic of expected addresses, the saturation point and the clear-versus-event priority. For these, the bench sweeps every fixed burst type, three transfer sizes and every cut position, ending each burst with either an IDLE or a NONSEQ.

// File: rtl/burst_watch_pkg.sv
package burst_watch_pkg;
  typedef enum logic [1:0] {
    TR_IDLE = 2'b00,
    TR_BUSY = 2'b01,
    TR_NSEQ = 2'b10,
    TR_SEQ  = 2'b11
  } trans_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_CONT  = 2'd2,
    ST_TERM  = 2'd3
  } trk_state_e;

  // Beats in a fixed burst; 0 means not a fixed-length burst.
  function automatic logic [4:0] fixed_len(input logic [2:0] b);
    case (b[2:1])
      2'b01:   fixed_len = 5'd4;
      2'b10:   fixed_len = 5'd8;
      2'b11:   fixed_len = 5'd16;
      default: fixed_len = 5'd0;
    endcase
  endfunction

  function automatic logic is_wrap(input logic [2:0] b);
    is_wrap = (b[2:1] != 2'b00) && !b[0];
  endfunction
endpackage

// File: rtl/bw_addr_pred.sv
module bw_addr_pred
  import burst_watch_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0] addr,
  input  logic [2:0]    size,
  input  logic [2:0]    burst,
  output logic [AW-1:0] next_addr
);
  localparam int LW = 5;

  logic [AW-1:0] step;
  logic [AW-1:0] span;
  logic [AW-1:0] mask;
  logic [AW-1:0] plain;

  always_comb begin
    step  = {{(AW-1){1'b0}}, 1'b1} << size;
    span  = {{(AW-LW){1'b0}}, fixed_len(burst)} << size;
    mask  = span - {{(AW-1){1'b0}}, 1'b1};
    plain = addr + step;
    if (is_wrap(burst))
      next_addr = (addr & ~mask) | (plain & mask);
    else
      next_addr = plain;
  end
endmodule

// File: rtl/bw_tracker.sv
module bw_tracker
  import burst_watch_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          acc,
  input  logic [1:0]    htrans,
  input  logic [2:0]    hburst,
  input  logic [2:0]    hsize,
  input  logic [AW-1:0] haddr,
  output logic [1:0]    state,
  output logic          term_ev,
  output logic          seq_bad
);
  trk_state_e    st_q;
  logic [4:0]    left_q;
  logic [2:0]    burst_q;
  logic [AW-1:0] exp_q;
  logic          exp_vld_q;

  logic [2:0]    burst_sel;
  logic [AW-1:0] pred;
  logic [4:0]    len_now;
  logic          owed;
  logic          is_nseq, is_seq, is_idle, is_busy;

  assign is_nseq   = acc && (htrans == TR_NSEQ);
  assign is_seq    = acc && (htrans == TR_SEQ);
  assign is_idle   = acc && (htrans == TR_IDLE);
  assign is_busy   = acc && (htrans == TR_BUSY);
  assign burst_sel = (htrans == TR_NSEQ) ? hburst : burst_q;
  assign len_now   = fixed_len(hburst);
  assign owed      = (left_q != 5'd0);
  assign term_ev   = owed && (is_idle || is_nseq);
  assign seq_bad   = is_seq && (!exp_vld_q || (haddr != exp_q));
  assign state     = st_q;

  bw_addr_pred #(.AW(AW)) u_pred (
    .addr      (haddr),
    .size      (hsize),
    .burst     (burst_sel),
    .next_addr (pred)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      left_q    <= '0;
      burst_q   <= '0;
      exp_q     <= '0;
      exp_vld_q <= 1'b0;
    end else if (is_nseq) begin
      st_q      <= ST_START;
      left_q    <= (len_now == 5'd0) ? 5'd0 : len_now - 5'd1;
      burst_q   <= hburst;
      exp_q     <= pred;
      exp_vld_q <= 1'b1;
    end else if (is_seq) begin
      st_q      <= ST_CONT;
      if (owed) left_q <= left_q - 5'd1;
      exp_q     <= pred;
      exp_vld_q <= 1'b1;
    end else if (is_idle) begin
      st_q      <= term_ev ? ST_TERM : ST_IDLE;
      left_q    <= '0;
      exp_vld_q <= 1'b0;
    end else if (is_busy) begin
      if (st_q == ST_TERM) st_q <= ST_IDLE;
    end else begin
      if (st_q == ST_TERM) st_q <= ST_IDLE;
    end
  end
endmodule

// File: rtl/bw_diag.sv
module bw_diag
  import burst_watch_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int LOG_D = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               acc,
  input  logic [1:0]         htrans,
  input  logic               term_ev,
  input  logic               seq_bad,
  input  logic               clr,
  output logic               term_pulse,
  output logic               early_flag,
  output logic               addr_err,
  output logic [CNT_W-1:0]   term_cnt,
  output logic [2*LOG_D-1:0] trans_log,
  output logic [LOG_D-1:0]   term_log
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (rst) begin
      term_pulse <= 1'b0;
      early_flag <= 1'b0;
      addr_err   <= 1'b0;
      term_cnt   <= '0;
    end else begin
      term_pulse <= term_ev;
      if (clr) begin
        term_cnt   <= term_ev ? CNT_ONE : '0;
        early_flag <= term_ev;
        addr_err   <= seq_bad;
      end else begin
        if (term_ev && term_cnt != CNT_MAX) term_cnt <= term_cnt + CNT_ONE;
        early_flag <= early_flag | term_ev;
        addr_err   <= addr_err | seq_bad;
      end
    end
  end

  generate
    for (genvar g = 0; g < LOG_D; g++) begin : g_log
      always_ff @(posedge clk) begin
        if (rst) begin
          trans_log[2*g +: 2] <= '0;
          term_log[g]         <= 1'b0;
        end else if (acc) begin
          if (g == 0) begin
            trans_log[1:0] <= htrans;
            term_log[0]    <= term_ev;
          end else begin
            trans_log[2*g +: 2] <= trans_log[2*(g-1) +: 2];
            term_log[g]         <= term_log[g-1];
          end
        end
      end
    end
  endgenerate
endmodule

// File: rtl/burst_watch.sv
module burst_watch
  import burst_watch_pkg::*;
#(
  parameter int AW    = 32,
  parameter int CNT_W = 16,
  parameter int LOG_D = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               hsel,
  input  logic               hready,
  input  logic [1:0]         htrans,
  input  logic [2:0]         hburst,
  input  logic [2:0]         hsize,
  input  logic [AW-1:0]      haddr,
  input  logic               clr,
  output logic [1:0]         state,
  output logic               term_pulse,
  output logic               early_flag,
  output logic               addr_err,
  output logic [CNT_W-1:0]   term_cnt,
  output logic [2*LOG_D-1:0] trans_log,
  output logic [LOG_D-1:0]   term_log
);
  logic acc;
  logic term_ev;
  logic seq_bad;

  assign acc = hsel && hready;

  bw_tracker #(.AW(AW)) u_trk (
    .clk     (clk),
    .rst     (rst),
    .acc     (acc),
    .htrans  (htrans),
    .hburst  (hburst),
    .hsize   (hsize),
    .haddr   (haddr),
    .state   (state),
    .term_ev (term_ev),
    .seq_bad (seq_bad)
  );

  bw_diag #(.CNT_W(CNT_W), .LOG_D(LOG_D)) u_diag (
    .clk        (clk),
    .rst        (rst),
    .acc        (acc),
    .htrans     (htrans),
    .term_ev    (term_ev),
    .seq_bad    (seq_bad),
    .clr        (clr),
    .term_pulse (term_pulse),
    .early_flag (early_flag),
    .addr_err   (addr_err),
    .term_cnt   (term_cnt),
    .trans_log  (trans_log),
    .term_log   (term_log)
  );
endmodule

// File: rtl/burst_watch_chk.sv
module burst_watch_chk #(
  parameter int CNT_W = 16,
  parameter int LOG_D = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               hsel,
  input logic               hready,
  input logic [1:0]         htrans,
  input logic               clr,
  input logic [1:0]         state,
  input logic               term_pulse,
  input logic               early_flag,
  input logic [CNT_W-1:0]   term_cnt,
  input logic [2*LOG_D-1:0] trans_log
);
  // R5
  idle_bus_log_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !(hsel && hready) |=> $stable(trans_log));

  // R5
  idle_bus_cnt_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!(hsel && hready) && !clr) |=> $stable(term_cnt));

  // R3
  pulse_cause_chk: assert property (@(posedge clk) disable iff (rst)
    (hsel && hready && htrans == 2'b11) |=> !term_pulse);

  // R3
  pulse_flag_chk: assert property (@(posedge clk) disable iff (rst)
    term_pulse |-> early_flag);

  // R7
  cnt_monotone_chk: assert property (@(posedge clk) disable iff (rst)
    !clr |=> (term_cnt >= $past(term_cnt)));

  // R3
  term_brief_chk: assert property (@(posedge clk) disable iff (rst)
    (state == 2'd3) |=> (state != 2'd3));

  // R9
  log_head_chk: assert property (@(posedge clk) disable iff (rst)
    (hsel && hready) |=> (trans_log[1:0] == $past(htrans)));
endmodule

bind burst_watch burst_watch_chk #(.CNT_W(CNT_W), .LOG_D(LOG_D)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .hsel       (hsel),
  .hready     (hready),
  .htrans     (htrans),
  .clr        (clr),
  .state      (state),
  .term_pulse (term_pulse),
  .early_flag (early_flag),
  .term_cnt   (term_cnt),
  .trans_log  (trans_log)
);

// File: tb/test_burst_watch.sv
`timescale 1ns/1ps
module test_burst_watch;
  localparam int AW = 32;
  localparam int CW = 4;
  localparam int LD = 8;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hsel = 1'b0, hready = 1'b1, clr = 1'b0;
  logic [1:0] htrans = 2'b00;
  logic [2:0] hburst = 3'b000, hsize = 3'b000;
  logic [AW-1:0] haddr = '0;
  logic [1:0] state;
  logic term_pulse, early_flag, addr_err;
  logic [CW-1:0] term_cnt;
  logic [2*LD-1:0] trans_log;
  logic [LD-1:0] term_log;

  int n_chk = 0, n_bad = 0, cyc = 0, exp_cnt = 0;

  always #2.5 clk = ~clk;

  burst_watch #(.AW(AW), .CNT_W(CW), .LOG_D(LD)) i_burst_watch (
    .clk(clk), .rst(rst), .hsel(hsel), .hready(hready), .htrans(htrans),
    .hburst(hburst), .hsize(hsize), .haddr(haddr), .clr(clr),
    .state(state), .term_pulse(term_pulse), .early_flag(early_flag),
    .addr_err(addr_err), .term_cnt(term_cnt), .trans_log(trans_log),
    .term_log(term_log)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // Drive one cycle at the falling edge; on return the rising edge has passed.
  task automatic put(input logic [1:0] t, input logic [2:0] b, input logic [2:0] s,
                     input logic [AW-1:0] a, input logic sel = 1'b1,
                     input logic rdy = 1'b1, input logic c = 1'b0);
    htrans = t; hburst = b; hsize = s; haddr = a; hsel = sel; hready = rdy; clr = c;
    @(negedge clk);
    clr = 1'b0;
  endtask

  function automatic int blen(input int b);
    return (b >= 6) ? 16 : (b >= 4) ? 8 : (b >= 2) ? 4 : 0;
  endfunction

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] a, input int b, input int s);
    longint inc = 1 << s;
    longint tot = blen(b) * inc;
    longint base;
    if (b >= 2 && (b % 2) == 0) begin
      base = a - (a % tot);
      return AW'(base + ((a - base + inc) % tot));
    end
    return a + AW'(inc);
  endfunction

  function automatic void bump();
    if (exp_cnt < CMAX) exp_cnt++;
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] a;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 state", state, 0);
    chk("R1 cnt", term_cnt, 0);
    chk("R1 flags", {early_flag, addr_err, term_pulse}, 0);
    chk("R1 logs", {trans_log, term_log}, 0);

    // R2 R3 R4 sweep: every fixed type, three sizes, every cut position, two endings
    for (int b = 2; b < 8; b++)
      for (int s = 0; s < 3; s++)
        for (int k = 1; k <= blen(b); k++)
          for (int e = 0; e < 2; e++) begin
            a = 32'h1000 + AW'(2 << s);
            put(2'b10, 3'(b), 3'(s), a);
            chk("R11 start", state, 1);
            for (int i = 1; i < k; i++) begin
              a = nxt(a, b, s);
              put(2'b11, 3'(b), 3'(s), a);
            end
            if (k > 1) chk("R11 cont", state, 2);
            if (e == 0) begin
              put(2'b00, 3'(b), 3'(s), '0);
              if (k < blen(b)) begin
                bump();
                chk("R3 pulse", term_pulse, 1);
                chk("R3 state term", state, 3);
                chk("R3 cnt", term_cnt, exp_cnt);
                chk("R9 term mark", term_log[0], 1);
              end else begin
                chk("R2 no pulse", term_pulse, 0);
                chk("R2 state idle", state, 0);
                chk("R2 cnt", term_cnt, exp_cnt);
              end
              put(2'b00, 3'd0, 3'd0, '0, 1'b0);
              chk("R3 back idle", state, 0);
            end else begin
              put(2'b10, 3'b011, 3'd2, 32'h2000);
              if (k < blen(b)) begin bump(); chk("R4 pulse", term_pulse, 1); end
              else chk("R2 no pulse nseq", term_pulse, 0);
              chk("R4 new start", state, 1);
              chk("R4 cnt", term_cnt, exp_cnt);
              put(2'b11, 3'b011, 3'd2, 32'h2004);
              put(2'b11, 3'b011, 3'd2, 32'h2008);
              put(2'b11, 3'b011, 3'd2, 32'h200c);
              put(2'b00, 3'd0, 3'd0, '0);
              chk("R4 new burst full", term_pulse, 0);
              chk("R4 cnt after", term_cnt, exp_cnt);
            end
          end
    chk("R10 wrap addresses ok", addr_err, 0);
    chk("R7 saturated", term_cnt, CMAX);

    // R8 clear
    put(2'b00, 3'd0, 3'd0, '0, 1'b0, 1'b1, 1'b1);
    exp_cnt = 0;
    chk("R8 cnt cleared", term_cnt, 0);
    chk("R8 flag cleared", early_flag, 0);

    // R5 deselected or stalled edges are ignored; BUSY neither counts nor ends
    put(2'b10, 3'b011, 3'd0, 32'h40);
    put(2'b00, 3'b011, 3'd0, 32'h0, 1'b0);
    chk("R5 hsel low", term_pulse, 0);
    put(2'b10, 3'b011, 3'd0, 32'h80, 1'b1, 1'b0);
    chk("R5 hready low", term_pulse, 0);
    chk("R5 log held", trans_log[3:0], 4'b0010);
    put(2'b11, 3'b011, 3'd0, 32'h41);
    put(2'b01, 3'b011, 3'd0, 32'h42);
    chk("R5 busy no pulse", term_pulse, 0);
    chk("R9 busy logged", trans_log[1:0], 2'b01);
    put(2'b11, 3'b011, 3'd0, 32'h42);
    put(2'b11, 3'b011, 3'd0, 32'h43);
    put(2'b00, 3'd0, 3'd0, '0);
    chk("R5 burst done after busy", {term_pulse, early_flag}, 0);
    chk("R9 history", trans_log[11:0], 12'b10_11_01_11_11_00);
    chk("R9 no mark", term_log[5:0], 0);

    // R6 SINGLE and INCR never early
    put(2'b10, 3'b000, 3'd2, 32'h100);
    put(2'b00, 3'd0, 3'd0, '0);
    chk("R6 single", term_pulse, 0);
    put(2'b10, 3'b001, 3'd2, 32'h100);
    put(2'b11, 3'b001, 3'd2, 32'h104);
    put(2'b00, 3'd0, 3'd0, '0);
    chk("R6 incr", {term_pulse, early_flag}, 0);
    chk("R10 incr ok", addr_err, 0);

    // R7 saturation from zero
    for (int j = 0; j < CMAX + 3; j++) begin
      put(2'b10, 3'b101, 3'd0, 32'h0);
      put(2'b00, 3'd0, 3'd0, '0);
      bump();
      chk("R7 count", term_cnt, exp_cnt);
    end

    // R8 clear with simultaneous early end
    put(2'b10, 3'b111, 3'd0, 32'h0);
    put(2'b00, 3'd0, 3'd0, '0, 1'b1, 1'b1, 1'b1);
    exp_cnt = 1;
    chk("R8 clear+event cnt", term_cnt, 1);
    chk("R8 clear+event flag", early_flag, 1);

    // R10 wrong SEQ address, and stray SEQ
    put(2'b10, 3'b011, 3'd2, 32'h200);
    put(2'b11, 3'b011, 3'd2, 32'h208);
    chk("R10 bad addr", addr_err, 1);
    put(2'b00, 3'd0, 3'd0, '0, 1'b1, 1'b1, 1'b1);
    chk("R8 addr_err cleared", addr_err, 0);
    put(2'b11, 3'b011, 3'd2, 32'h300);
    chk("R10 stray seq", addr_err, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule